// File: doc/BRIEF.md
# Microprogram Sequencer with Condition Select

This block produces the next control-memory address for a microprogrammed control unit. A 6-bit address register selects one of 64 microinstruction words in an on-block control memory. Each word holds four fields: a 16-bit control field for the datapath, a condition selector, an address-source bit and a 6-bit jump target. The control field of the word at the current address drives a combinational output.

On every clock edge the register either steps to the following address or loads a jump address. An eight-input condition multiplexer makes this choice. Its inputs are two constants and the datapath status flags, some true and some inverted. A second multiplexer picks where a taken jump goes: the word's own target field or an external address input. That input is used, for example, to dispatch on an opcode.

The control memory is filled with a fixed pattern computed from each address. This lets a bench predict every word. The datapath is not part of this block; its carry, zero, sign and overflow flags arrive as inputs.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the address register to 0 at the next rising clock edge.
- R2: `ctrl_out` always equals the control field of the memory word at the current address. For address a, that field is {a[5:0], ~a[5:0], a[3:0]}.
- R3: The condition selector of the word at address a is a[2:0]. It chooses the jump condition as follows: 0 never, 1 always, 2 carry, 3 not carry, 4 zero, 5 not zero, 6 sign, 7 overflow.
- R4: When the condition is true and the source bit is 0, the register loads the word's target field. For address a, that field is (5*a+3) mod 64.
- R5: When the condition is true and the source bit is 1, the register loads `ext_addr`. For address a, the source bit is a[3].
- R6: When the condition is false, the register advances by one.
- R7: Advancing from address 63 wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_c | input | 1 | Datapath carry flag |
| flag_z | input | 1 | Datapath zero flag |
| flag_s | input | 1 | Datapath sign flag |
| flag_v | input | 1 | Datapath overflow flag |
| ext_addr | input | 6 | External jump address |
| car_addr | output | 6 | Current control address |
| ctrl_out | output | 16 | Control field of the current microinstruction |

## Verification
A wrong address register shows up on `car_addr` one clock edge after the faulty decision. It also shows on `ctrl_out` at once, since that output is decoded from the same address. A condition inverted or mapped to the wrong flag sends the walk to the wrong address in that same cycle. Because the model tracks the address on every cycle, the first miscompare points to the exact edge. A fault in the memory pattern shows as a `ctrl_out` mismatch at whichever address holds the faulty word.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W = 6;
    localparam int CTRL_W = 16;
    localparam int SEL_W  = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int TGT_MUL = 5;
    localparam int TGT_ADD = 3;

    typedef enum logic [SEL_W-1:0] {
        COND_NEVER  = 3'd0,
        COND_ALWAYS = 3'd1,
        COND_CARRY  = 3'd2,
        COND_NCARRY = 3'd3,
        COND_ZERO   = 3'd4,
        COND_NZERO  = 3'd5,
        COND_SIGN   = 3'd6,
        COND_OVFL   = 3'd7
    } cond_sel_e;

    typedef enum logic {
        SRC_FIELD = 1'b0,
        SRC_EXT   = 1'b1
    } addr_src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] target;
        cond_sel_e         cond_sel;
        addr_src_e         addr_src;
        logic [CTRL_W-1:0] ctrl;
    } uinstr_t;

    typedef struct packed {
        logic carry;
        logic zero;
        logic sign;
        logic ovfl;
    } flags_t;

    function automatic uinstr_t rom_word(input logic [ADDR_W-1:0] a);
        uinstr_t w;
        w.ctrl     = {a, ~a, a[3:0]};
        w.addr_src = addr_src_e'(a[3]);
        w.cond_sel = cond_sel_e'(a[SEL_W-1:0]);
        w.target   = ADDR_W'(int'(a) * TGT_MUL + TGT_ADD);
        return w;
    endfunction

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  cond_sel_e sel,
    input  flags_t    flags,
    output logic      cond
);
    always_comb begin
        case (sel)
            COND_NEVER:  cond = 1'b0;
            COND_ALWAYS: cond = 1'b1;
            COND_CARRY:  cond = flags.carry;
            COND_NCARRY: cond = ~flags.carry;
            COND_ZERO:   cond = flags.zero;
            COND_NZERO:  cond = ~flags.zero;
            COND_SIGN:   cond = flags.sign;
            COND_OVFL:   cond = flags.ovfl;
            default:     cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_ctrl_rom.sv
module useq_ctrl_rom
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W,
    localparam int ND = 1 << AW
) (
    input  logic [AW-1:0] addr,
    output uinstr_t       word
);
    uinstr_t mem [ND];

    for (genvar i = 0; i < ND; i++) begin : g_word
        assign mem[i] = rom_word(ADDR_W'(i));
    end

    assign word = mem[addr];
endmodule

// File: rtl/useq_car.sv
module useq_car
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] car
);
    always_ff @(posedge clk) begin
        if (rst)       car <= '0;
        else if (take) car <= load_addr;
        else           car <= car + AW'(1);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (car == '0)); // R1
    AST_LOAD_WHEN_TAKEN: assert property (@(posedge clk) disable iff (rst)
        take |=> (car == $past(load_addr))); // R4
    AST_STEP_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        !take |=> (car == AW'($past(car) + 1'b1))); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!take && car == {AW{1'b1}}) |=> (car == '0)); // R7
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_v,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] car_addr,
    output logic [CTRL_W-1:0] ctrl_out
);
    uinstr_t           cur;
    flags_t            flags;
    logic              take;
    logic [ADDR_W-1:0] load_addr;

    assign flags = '{carry: flag_c, zero: flag_z, sign: flag_s, ovfl: flag_v};

    useq_ctrl_rom #(.AW(ADDR_W)) u_rom (
        .addr (car_addr),
        .word (cur)
    );

    useq_cond_mux u_cond (
        .sel   (cur.cond_sel),
        .flags (flags),
        .cond  (take)
    );

    assign load_addr = (cur.addr_src == SRC_EXT) ? ext_addr : cur.target;

    useq_car #(.AW(ADDR_W)) u_car (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .load_addr (load_addr),
        .car       (car_addr)
    );

    assign ctrl_out = cur.ctrl;

    AST_NEVER_STEPS: assert property (@(posedge clk) disable iff (rst)
        (cur.cond_sel == COND_NEVER) |=> (car_addr == ADDR_W'($past(car_addr) + 1'b1))); // R3
    AST_ALWAYS_JUMPS: assert property (@(posedge clk) disable iff (rst)
        (cur.cond_sel == COND_ALWAYS && cur.addr_src == SRC_FIELD)
        |=> (car_addr == $past(cur.target))); // R4
    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (take && cur.addr_src == SRC_EXT) |=> (car_addr == $past(ext_addr))); // R5
    AST_CTRL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        ctrl_out[CTRL_W-1 -: ADDR_W] == car_addr); // R2
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, fc, fz, fs, fv;
    logic [5:0] ext;
    logic [5:0] car_addr;
    logic [15:0] ctrl_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [5:0] model = '0;

    useq_sequencer u_dut (
        .clk(clk), .rst(rst), .flag_c(fc), .flag_z(fz), .flag_s(fs), .flag_v(fv),
        .ext_addr(ext), .car_addr(car_addr), .ctrl_out(ctrl_out)
    );

    function automatic logic [15:0] exp_ctrl(input logic [5:0] a);
        return {a, ~a, a[3:0]};
    endfunction

    function automatic logic [5:0] exp_target(input logic [5:0] a);
        int t;
        t = (int'(a) * 5 + 3) % 64;
        return t[5:0];
    endfunction

    function automatic bit exp_cond(input logic [2:0] sel, input bit c, z, s, v);
        case (sel)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return c;
            3'd3: return !c;
            3'd4: return z;
            3'd5: return !z;
            3'd6: return s;
            default: return v;
        endcase
    endfunction

    // Called just after a falling edge: drive, let one rising edge pass, check.
    task automatic apply(input bit r, input bit c, z, s, v, input logic [5:0] e);
        logic [5:0] nxt;
        string tag;
        rst = r; fc = c; fz = z; fs = s; fv = v; ext = e;
        if (r) begin
            nxt = '0; tag = "R1 reset";
        end else if (exp_cond(model[2:0], c, z, s, v)) begin
            if (model[3]) begin nxt = e; tag = "R5 external jump, R3 select"; end
            else begin nxt = exp_target(model); tag = "R4 field jump, R3 select"; end
        end else begin
            nxt = model + 6'd1;
            tag = (model == 6'd63) ? "R7 wrap, R3 select" : "R6 step, R3 select";
        end
        @(negedge clk);
        n_vec++;
        if (car_addr !== nxt) begin
            n_bad++;
            $display("FAIL %s at addr %0d sel %0d: car_addr=%0d expected %0d",
                     tag, model, model[2:0], car_addr, nxt);
        end
        n_vec++;
        if (ctrl_out !== exp_ctrl(nxt)) begin
            n_bad++;
            $display("FAIL R2 ctrl_out at addr %0d: got %h expected %h",
                     nxt, ctrl_out, exp_ctrl(nxt));
        end
        model = nxt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0123));
        rst = 1'b1; fc = 0; fz = 0; fs = 0; fv = 0; ext = '0;
        @(negedge clk);
        // R1: reset state, twice
        apply(1, 0, 0, 0, 0, 6'd0);
        apply(1, 1, 1, 1, 1, 6'd17);
        // R3 select 0 steps, select 1 jumps by field (R4), then external (R5)
        apply(0, 1, 1, 1, 1, 6'd40);   // 0 -> 1
        apply(0, 0, 0, 0, 0, 6'd40);   // 1 -> 8 (always)
        apply(0, 1, 1, 1, 1, 6'd40);   // 8 -> 9 (never)
        apply(0, 0, 0, 0, 0, 6'd63);   // 9 -> 63 (always, external)
        // R7: overflow select false at 63 wraps
        apply(0, 1, 1, 1, 0, 6'd5);    // 63 -> 0
        // back to 63, then overflow true takes external R5
        apply(0, 0, 0, 0, 0, 6'd0);
        apply(0, 0, 0, 0, 0, 6'd0);
        apply(0, 0, 0, 0, 0, 6'd0);
        apply(0, 0, 0, 0, 0, 6'd63);
        apply(0, 0, 0, 0, 1, 6'd21);   // 63 -> 21
        // random walk; every flag in both polarities across all selects
        for (int i = 0; i < 4000; i++) begin
            bit r;
            r = ($urandom % 97) == 0;
            apply(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  6'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule